// File: doc/BRIEF.md
# Dual-Master Bus Ownership Controller

This block decides which of two upstream masters drives a shared downstream two-wire bus. Each master has its own control register. In that register the master sees its own ownership bit, a mirrored copy of the other master's ownership bit, its own bus-enable bit and a mirror of the other master's enable bit. A master takes the bus by writing into its own ownership bit the value it just read from the mirror. It switches the connection on or off by choosing whether its enable bit matches or differs from the other master's. The registers are written through parallel strobe and data ports and read back through parallel data outputs.

The block drives a one-hot channel select toward the pass gates. That select is none, channel 0 or channel 1. The block never moves the select straight from one channel to the other: it always spends at least one cycle on none. When the build enables recovery, the block asks an external sequencer for a recovery pulse before each new connection, and it makes the connection only when the sequencer reports done. A master whose connection is removed receives a latched lost-bus flag and an active-low interrupt. A test bit lets each master force its own interrupt for a functional check.

Top module: `bus_owner_sel`

## Requirements
- R1: Each register read shows own ownership at bit 0, the other master's ownership at bit 1, own enable at bit 2, the other master's enable at bit 3, the test bit at bit 4 and the lost flag at bit 6. Master 0's mirror of master 1's ownership bit is direct, and master 1's mirror of master 0's ownership bit is inverted. Equal bits 0 and 1 mean that the reader owns the bus.
- R2: When a master writes bit 0 equal to the bit 1 it last read, while keeping the enable state, it becomes the owner and the select moves to its channel (channel 0 is select 01, channel 1 is select 10).
- R3: The bus is enabled when the two masters' enable bits differ. When they are equal, the select returns to 00 and no recovery request is made.
- R4: The select output never has more than one bit set.
- R5: The select never goes directly from one channel to the other. At least one cycle of 00 lies between two different channels.
- R6: With recovery enabled, every connection from 00 is preceded by a one-cycle recovery request pulse. The select stays 00 until the recovery-done input is seen high, and the new channel appears in the cycle after that.
- R7: If the pending target changes while the block waits for recovery done, the wait is abandoned. A later done pulse then connects nothing.
- R8: When the select leaves a channel, that master's lost flag (read bit 6) is set and its interrupt output goes low. Writing that master's register with bit 7 set clears the flag and releases the interrupt.
- R9: Writing a master's bit 4 high forces that master's interrupt low without changing the selection. Writing it low releases the interrupt.
- R10: After reset the select is 01 when parameter INIT_CH0 is 1 and 00 when it is 0. In both variants the ownership bits, the test bits and the lost flags are 0, and master 0's enable bit equals INIT_CH0.
- R11: Pulling the active-low reset input low during operation returns the select, the registers and the interrupts to the reset state of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb_i | input | 2 | Register write strobe, one bit per master |
| wr_data0_i | input | 8 | Write data for master 0's register |
| wr_data1_i | input | 8 | Write data for master 1's register |
| rec_done_i | input | 1 | Recovery sequencer reports completion |
| rd_data0_o | output | 8 | Register view seen by master 0 |
| rd_data1_o | output | 8 | Register view seen by master 1 |
| sel_o | output | 2 | One-hot downstream channel select |
| rec_req_o | output | 1 | One-cycle request for bus recovery |
| irq_n_o | output | 2 | Active-low interrupt, one per master |

## Verification
A handover between the two masters is watched on every cycle. A design that skipped the idle gap would show 01 followed directly by 10, and a select with both bits set would also be caught. The bench withholds recovery done for several cycles, so a design that connected early would show a channel while the request is still outstanding. It also withdraws a request during the recovery wait and then sends a stray done pulse; a design without the abort would connect a channel nobody wants. The inverted mirror for master 1 is checked through the read values, so a design with a symmetric mirror would grant the bus to both views or to neither. The lost flag and its clear are checked at both interrupt pins.

// File: rtl/bus_owner_pkg.sv
package bus_owner_pkg;
  localparam int NCH   = 2;
  localparam int REG_W = 8;
  localparam int SEL_W = NCH;

  // field positions inside each master's register view
  localparam int B_OWN     = 0;
  localparam int B_OTH_OWN = 1;
  localparam int B_ON      = 2;
  localparam int B_OTH_ON  = 3;
  localparam int B_TEST    = 4;
  localparam int B_LOST    = 6;
  localparam int B_ACK     = 7;

  typedef enum logic {
    ST_STEADY = 1'b0,
    ST_RECOV  = 1'b1
  } conn_st_e;
endpackage

// File: rtl/bos_rst_sync.sv
module bos_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bos_ctrl_regs.sv
module bos_ctrl_regs
  import bus_owner_pkg::*;
#(
  parameter bit INIT_CH0 = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   wr_stb_i,
  input  logic [REG_W-1:0] wr_data_i [NCH],
  input  logic [NCH-1:0]   lost_set_i,
  output logic [REG_W-1:0] rd_data_o [NCH],
  output logic [SEL_W-1:0] target_o,
  output logic [NCH-1:0]   flag_irq_o
);
  logic [NCH-1:0] own_q;
  logic [NCH-1:0] on_q;

  for (genvar g = 0; g < NCH; g++) begin : g_mst
    localparam bit ON_RST = (g == 0) ? INIT_CH0 : 1'b0;

    logic own_r, on_r, test_r, lost_r;
    logic own_n, on_n, test_n, lost_n;
    logic oth_own, oth_on;
    logic [REG_W-1:0] view;
    logic unused_bits;

    assign unused_bits = ^{wr_data_i[g][B_OTH_OWN], wr_data_i[g][B_OTH_ON],
                           wr_data_i[g][5], wr_data_i[g][B_LOST]};

    always_comb begin
      own_n  = own_r;
      on_n   = on_r;
      test_n = test_r;
      lost_n = lost_r;
      if (wr_stb_i[g]) begin
        own_n  = wr_data_i[g][B_OWN];
        on_n   = wr_data_i[g][B_ON];
        test_n = wr_data_i[g][B_TEST];
        if (wr_data_i[g][B_ACK]) lost_n = 1'b0;
      end
      if (lost_set_i[g]) lost_n = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        own_r  <= 1'b0;
        on_r   <= ON_RST;
        test_r <= 1'b0;
        lost_r <= 1'b0;
      end else begin
        own_r  <= own_n;
        on_r   <= on_n;
        test_r <= test_n;
        lost_r <= lost_n;
      end
    end

    // master 1 sees master 0's ownership bit inverted
    if (g == 0) begin : g_direct
      assign oth_own = own_q[1];
    end else begin : g_invert
      assign oth_own = ~own_q[0];
    end
    assign oth_on = on_q[NCH-1-g];

    always_comb begin
      view            = '0;
      view[B_OWN]     = own_r;
      view[B_OTH_OWN] = oth_own;
      view[B_ON]      = on_r;
      view[B_OTH_ON]  = oth_on;
      view[B_TEST]    = test_r;
      view[B_LOST]    = lost_r;
    end

    assign own_q[g]      = own_r;
    assign on_q[g]       = on_r;
    assign rd_data_o[g]  = view;
    assign flag_irq_o[g] = lost_r | test_r;
  end

  logic owner_hi, bus_en;
  assign owner_hi = own_q[0] ^ own_q[1];
  assign bus_en   = on_q[0] ^ on_q[1];
  assign target_o = !bus_en ? '0 : (owner_hi ? SEL_W'(2'b10) : SEL_W'(2'b01));
endmodule

// File: rtl/bos_conn_fsm.sv
module bos_conn_fsm
  import bus_owner_pkg::*;
#(
  parameter bit INIT_CH0     = 1'b1,
  parameter bit USE_RECOVERY = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] target_i,
  input  logic             rec_done_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             rec_req_o,
  output logic [NCH-1:0]   lost_set_o
);
  localparam logic [SEL_W-1:0] SEL_RST = INIT_CH0 ? SEL_W'(1) : '0;

  conn_st_e         st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [SEL_W-1:0] pend_q, pend_d;
  logic             req_q, req_d;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    pend_d = pend_q;
    req_d  = 1'b0;
    unique case (st_q)
      ST_STEADY: begin
        if (target_i != sel_q) begin
          if (sel_q != '0) begin
            sel_d = '0;                 // break first
          end else if (USE_RECOVERY) begin
            pend_d = target_i;
            req_d  = 1'b1;
            st_d   = ST_RECOV;
          end else begin
            sel_d = target_i;
          end
        end
      end
      ST_RECOV: begin
        if (target_i != pend_q) begin
          st_d = ST_STEADY;             // request withdrawn
        end else if (rec_done_i) begin
          sel_d = pend_q;
          st_d  = ST_STEADY;
        end
      end
      default: st_d = ST_STEADY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_STEADY;
      sel_q  <= SEL_RST;
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign sel_o      = sel_q;
  assign rec_req_o  = req_q;
  assign lost_set_o = sel_q & ~sel_d;
endmodule

// File: rtl/bus_owner_sel.sv
module bus_owner_sel
  import bus_owner_pkg::*;
#(
  parameter bit INIT_CH0     = 1'b1,
  parameter bit USE_RECOVERY = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   wr_stb_i,
  input  logic [REG_W-1:0] wr_data0_i,
  input  logic [REG_W-1:0] wr_data1_i,
  input  logic             rec_done_i,
  output logic [REG_W-1:0] rd_data0_o,
  output logic [REG_W-1:0] rd_data1_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             rec_req_o,
  output logic [NCH-1:0]   irq_n_o
);
  logic             rst_sync_n;
  logic [REG_W-1:0] wdata [NCH];
  logic [REG_W-1:0] rdata [NCH];
  logic [SEL_W-1:0] target;
  logic [NCH-1:0]   lost_set;
  logic [NCH-1:0]   flag_irq;

  assign wdata[0] = wr_data0_i;
  assign wdata[1] = wr_data1_i;

  bos_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  bos_ctrl_regs #(.INIT_CH0(INIT_CH0)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_stb_i  (wr_stb_i),
    .wr_data_i (wdata),
    .lost_set_i(lost_set),
    .rd_data_o (rdata),
    .target_o  (target),
    .flag_irq_o(flag_irq)
  );

  bos_conn_fsm #(.INIT_CH0(INIT_CH0), .USE_RECOVERY(USE_RECOVERY)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .target_i  (target),
    .rec_done_i(rec_done_i),
    .sel_o     (sel_o),
    .rec_req_o (rec_req_o),
    .lost_set_o(lost_set)
  );

  assign rd_data0_o = rdata[0];
  assign rd_data1_o = rdata[1];
  assign irq_n_o    = ~flag_irq;
endmodule

// File: rtl/bus_owner_sel_chk.sv
module bus_owner_sel_chk
  import bus_owner_pkg::*;
#(
  parameter bit USE_RECOVERY = 1'b1
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic [SEL_W-1:0] sel_o,
  input logic             rec_req_o,
  input logic             rec_done_i,
  input logic [NCH-1:0]   irq_n_o,
  input logic [REG_W-1:0] rd_data0_o,
  input logic [REG_W-1:0] rd_data1_o
);
  assert_sel_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(sel_o));

  assert_break_first_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(sel_o) != '0 && sel_o != '0) |-> sel_o == $past(sel_o));

  assert_req_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rec_req_o |=> !rec_req_o);

  if (USE_RECOVERY) begin : g_rec
    assert_connect_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
      ($past(sel_o) == '0 && sel_o != '0) |-> $past(rec_done_i));
  end

  assert_lost_irq0_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(sel_o[0]) && !sel_o[0]) |-> (!irq_n_o[0] && rd_data0_o[B_LOST]));

  assert_lost_irq1_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(sel_o[1]) && !sel_o[1]) |-> (!irq_n_o[1] && rd_data1_o[B_LOST]));

  assert_test_irq0_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_data0_o[B_TEST] |-> !irq_n_o[0]);

  assert_test_irq1_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    rd_data1_o[B_TEST] |-> !irq_n_o[1]);
endmodule

bind bus_owner_sel bus_owner_sel_chk #(.USE_RECOVERY(USE_RECOVERY)) i_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .sel_o     (sel_o),
  .rec_req_o (rec_req_o),
  .rec_done_i(rec_done_i),
  .irq_n_o   (irq_n_o),
  .rd_data0_o(rd_data0_o),
  .rd_data1_o(rd_data1_o)
);

// File: tb/test_bus_owner_sel.sv
module test_bus_owner_sel;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] wr_stb = '0;
  logic [7:0] wd0 = '0, wd1 = '0;
  logic       rec_done = 1'b0;
  logic [7:0] rd0, rd1, rdb0, rdb1;
  logic [1:0] sel, selb, irq_n, irqb_n;
  logic       rec_req, rec_reqb;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_sel i_bus_owner_sel (
    .clk_i(clk), .rst_ni(rst_ni), .wr_stb_i(wr_stb),
    .wr_data0_i(wd0), .wr_data1_i(wd1), .rec_done_i(rec_done),
    .rd_data0_o(rd0), .rd_data1_o(rd1), .sel_o(sel),
    .rec_req_o(rec_req), .irq_n_o(irq_n)
  );

  bus_owner_sel #(.INIT_CH0(1'b0)) i_bus_owner_sel_none (
    .clk_i(clk), .rst_ni(rst_ni), .wr_stb_i(2'b00),
    .wr_data0_i(8'h00), .wr_data1_i(8'h00), .rec_done_i(1'b0),
    .rd_data0_o(rdb0), .rd_data1_o(rdb1), .sel_o(selb),
    .rec_req_o(rec_reqb), .irq_n_o(irqb_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // per-cycle select monitor for R4 and R5
  logic [1:0] sel_prev = '0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sel === 2'b11) begin
        n_fail++;
        $display("FAIL R4 select: actual %0h expected at most one bit", sel);
      end
      if (sel_prev != 2'b00 && sel != 2'b00 && sel != sel_prev) begin
        n_fail++;
        $display("FAIL R5 direct switch: actual %0h expected 0 after %0h", sel, sel_prev);
      end
    end
    sel_prev = sel;
  end

  task automatic wr(input int m, input logic [7:0] d);
    @(negedge clk);
    if (m == 0) wd0 = d; else wd1 = d;
    wr_stb[m] = 1'b1;
    @(negedge clk);
    wr_stb = '0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      if (rec_req) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic pulse_done();
    rec_done = 1'b1;
    @(negedge clk);
    rec_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R10", "sel ch0 variant", sel, 2'b01);
    chk("R1",  "rd0 after reset", rd0, 8'h04);
    chk("R1",  "rd1 after reset (inverted mirror)", rd1, 8'h0A);
    chk("R10", "irq after reset", irq_n, 2'b11);
    chk("R10", "rec_req after reset", rec_req, 1'b0);
    chk("R10", "sel none variant", selb, 2'b00);
    chk("R10", "rd0 none variant", rdb0, 8'h00);
    chk("R10", "rd1 none variant", rdb1, 8'h02);
  endtask

  task automatic t_handover_to_1();
    bit seen;
    wr(1, 8'h01);
    chk("R1", "rd1 after claim", rd1, 8'h0B);
    chk("R1", "rd0 after claim", rd0, 8'h06);
    @(negedge clk);
    chk("R5", "sel gap", sel, 2'b00);
    chk("R8", "irq0 lost", irq_n, 2'b10);
    chk("R8", "rd0 lost flag", rd0, 8'h46);
    wait_req(seen);
    chk("R6", "rec_req seen", seen, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6", "sel held until done", sel, 2'b00);
    chk("R6", "req is one pulse", rec_req, 1'b0);
    pulse_done();
    chk("R2", "sel ch1", sel, 2'b10);
  endtask

  task automatic t_ack_lost0();
    wr(0, 8'h84);
    chk("R8", "irq0 released", irq_n, 2'b11);
    chk("R8", "rd0 flag cleared", rd0, 8'h06);
  endtask

  task automatic t_takeback_0();
    bit seen;
    wr(0, 8'h05);
    chk("R1", "rd0 claim view", rd0, 8'h07);
    @(negedge clk);
    chk("R5", "sel gap", sel, 2'b00);
    chk("R8", "irq1 lost", irq_n, 2'b01);
    chk("R8", "rd1 lost view", rd1, 8'h49);
    wait_req(seen);
    chk("R6", "rec_req seen", seen, 1'b1);
    @(negedge clk);
    pulse_done();
    chk("R2", "sel back to ch0", sel, 2'b01);
    wr(1, 8'h81);
    chk("R8", "irq1 released", irq_n, 2'b11);
    chk("R8", "rd1 cleared", rd1, 8'h09);
  endtask

  task automatic t_bus_off();
    wr(0, 8'h01);
    @(negedge clk);
    chk("R3", "sel off", sel, 2'b00);
    chk("R8", "irq0 on disconnect", irq_n, 2'b10);
    repeat (4) begin
      @(negedge clk);
      if (rec_req) chk("R3", "no recovery when off", rec_req, 1'b0);
    end
    chk("R3", "sel stays off", sel, 2'b00);
    wr(0, 8'h81);
    chk("R8", "irq0 cleared", irq_n, 2'b11);
  endtask

  task automatic t_abort();
    bit seen;
    wr(1, 8'h04);
    wait_req(seen);
    chk("R7", "rec_req for ch1", seen, 1'b1);
    wr(0, 8'h05);
    @(negedge clk);
    pulse_done();
    repeat (3) begin
      @(negedge clk);
      if (sel != 2'b00) chk("R7", "stray done ignored", sel, 2'b00);
    end
    chk("R7", "sel after stray done", sel, 2'b00);
    chk("R7", "no lost after abort", irq_n, 2'b11);
  endtask

  task automatic t_test_irq();
    wr(1, 8'h14);
    chk("R9", "irq1 forced", irq_n, 2'b01);
    chk("R9", "rd1 test bit", rd1, 8'h1C);
    chk("R9", "sel unchanged", sel, 2'b00);
    wr(1, 8'h04);
    chk("R9", "irq1 released", irq_n, 2'b11);
  endtask

  task automatic t_reset_mid();
    wr(0, 8'h10);
    do_reset();
    chk("R11", "sel after reset", sel, 2'b01);
    chk("R11", "rd0 after reset", rd0, 8'h04);
    chk("R11", "rd1 after reset", rd1, 8'h0A);
    chk("R11", "irq after reset", irq_n, 2'b11);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_handover_to_1();
    t_ack_lost0();
    t_takeback_0();
    t_bus_off();
    t_abort();
    t_test_irq();
    t_reset_mid();
    chk("R4", "monitor clean", (n_fail == 0) ? 1 : 0, 1);
    summary();
    $finish;
  end
endmodule